// File: doc/BRIEF.md
# Dual-Port Core to AHB-Lite Master Bridge

This block joins a small processor core's two memory ports to a single AHB-Lite master. One port fetches instructions and the other handles loads and stores. Both use a request / grant / response-valid handshake: the core holds a request until it sees the grant, then waits for the valid pulse that carries the read data back.

The bridge serves one transaction at a time and does not pipeline them. A four-state controller (idle, data request, instruction request, waiting for the response) picks a port while idle. When both ports ask in the same cycle, the load/store port wins. The controller then places the address phase on the bus and grants the port in the cycle that phase is accepted. It waits in the data phase until the slave signals ready, then returns the read data with a one-cycle valid to the port that started the transfer.

For loads and stores, the byte-enable pattern sets the transfer size and the low address bits. Store data moves onto the write-data bus one cycle after its address phase.

Top module: `core_ahb_bridge`

## Requirements
- R1: While rst_ni is low, htrans_o is 2'b00, hwrite_o is 0, and both grant and both response-valid outputs are 0.
- R2: When both ports request while the controller is idle, the load/store port is granted first. The instruction request stays pending and is served after that transfer has completed.
- R3: A grant is a one-cycle pulse to a single port. It is asserted in the cycle where htrans_o is 2'b10 and hready_i is 1, and that address phase belongs to the granted port.
- R4: htrans_o only takes the values 2'b00 (no transfer) and 2'b10 (NONSEQ). Each accepted request gives exactly one NONSEQ address phase.
- R5: hsize_o is 3'b000 for a byte, 3'b001 for a halfword and 3'b010 for a word. For the load/store port:
  - the number of set enable bits picks the size (1, 2 or 4);
  - haddr_o[1:0] is the index of the lowest set enable bit;
  - haddr_o[31:2] comes from data_addr_i[31:2], and data_addr_i[1:0] is ignored.
- R6: Instruction fetches are words at instr_addr_i. hwrite_o is 1 only during the address phase of a store. In the following data phase, hwdata_o equals the store's data_wdata_i.
- R7: After an accepted address phase, htrans_o is 2'b00 for the whole data phase. The data phase lasts until hready_i is sampled high, and no new address phase starts before then.
- R8: In the cycle hready_i completes the data phase, the starting port gets rvalid for one cycle with rdata equal to hrdata_i. The other port's rvalid stays 0.
- R9: While an address phase is waiting with hready_i low, htrans_o, haddr_o, hsize_o and hwrite_o hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| instr_req_i | input | 1 | Instruction fetch request |
| instr_addr_i | input | AW | Fetch address |
| instr_gnt_o | output | 1 | Fetch request accepted |
| instr_rvalid_o | output | 1 | Fetch data valid |
| instr_rdata_o | output | DW | Fetched word |
| data_req_i | input | 1 | Load/store request |
| data_we_i | input | 1 | 1 for store, 0 for load |
| data_be_i | input | DW/8 | Byte enables |
| data_addr_i | input | AW | Load/store address (low bits ignored) |
| data_wdata_i | input | DW | Store data, lane aligned |
| data_gnt_o | output | 1 | Load/store request accepted |
| data_rvalid_o | output | 1 | Load/store completed |
| data_rdata_o | output | DW | Load data |
| haddr_o | output | AW | Bus address |
| htrans_o | output | 2 | Transfer type |
| hsize_o | output | 3 | Transfer size |
| hwrite_o | output | 1 | Write transfer |
| hwdata_o | output | DW | Write data |
| hready_i | input | 1 | Transfer complete / slave ready |
| hrdata_i | input | DW | Read data |

## Verification
The hardest situation to reach is a stretched transaction with a competing request parked behind it. Here the slave holds hready_i low in the address phase and again in the data phase, while the instruction port keeps requesting. The bench gets there by loading both port queues in the same cycle and driving hready_i from patterns that are low three cycles in four and from a pseudo-random sequence. A behavioural model checks every clock that the pending fetch is neither granted early nor lost, and that the address phase holds still while it waits.

// File: rtl/ahb_bridge_pkg.sv
package ahb_bridge_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_DREQ = 2'd1,
    ST_IREQ = 2'd2,
    ST_WAIT = 2'd3
  } ctrl_state_e;

  typedef enum logic {
    SRC_INSTR = 1'b0,
    SRC_DATA  = 1'b1
  } src_e;

  // BUSY (2'b01) exists on the bus but is never issued here
  localparam logic [1:0] HTRANS_IDLE   = 2'b00;
  localparam logic [1:0] HTRANS_NONSEQ = 2'b10;

endpackage

// File: rtl/bridge_be_decode.sv
module bridge_be_decode #(
  parameter  int unsigned DW   = 32,
  localparam int unsigned BW   = DW / 8,
  localparam int unsigned OFFW = $clog2(BW)
) (
  input  logic [BW-1:0]   be_i,
  output logic [2:0]      size_o,
  output logic [OFFW-1:0] offs_o
);

  int unsigned cnt;

  always_comb begin
    cnt    = 0;
    offs_o = '0;
    size_o = '0;
    // lowest enabled lane gives the offset
    for (int i = BW - 1; i >= 0; i--) begin
      if (be_i[i]) offs_o = OFFW'(i);
    end
    for (int i = 0; i < BW; i++) begin
      cnt = cnt + 32'(be_i[i]);
    end
    for (int k = 0; k <= OFFW; k++) begin
      if (cnt == (32'd1 << k)) size_o = 3'(k);
    end
  end

endmodule

// File: rtl/bridge_ctrl.sv
module bridge_ctrl
  import ahb_bridge_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic instr_req_i,
  input  logic data_req_i,
  input  logic hready_i,
  output logic capture_o,
  output src_e cap_src_o,
  output logic addr_phase_o,
  output logic instr_gnt_o,
  output logic data_gnt_o,
  output logic instr_done_o,
  output logic data_done_o
);

  ctrl_state_e state_q, state_d;
  src_e        owner_q;

  always_comb begin
    state_d     = state_q;
    capture_o   = 1'b0;
    cap_src_o   = SRC_DATA;
    instr_gnt_o = 1'b0;
    data_gnt_o  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (data_req_i) begin
          capture_o = 1'b1;
          cap_src_o = SRC_DATA;
          state_d   = ST_DREQ;
        end else if (instr_req_i) begin
          capture_o = 1'b1;
          cap_src_o = SRC_INSTR;
          state_d   = ST_IREQ;
        end
      end
      ST_DREQ: begin
        data_gnt_o = hready_i;
        if (hready_i) state_d = ST_WAIT;
      end
      ST_IREQ: begin
        instr_gnt_o = hready_i;
        if (hready_i) state_d = ST_WAIT;
      end
      ST_WAIT: begin
        if (hready_i) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      owner_q <= SRC_INSTR;
    end else begin
      state_q <= state_d;
      if (capture_o) owner_q <= cap_src_o;
    end
  end

  assign addr_phase_o = (state_q == ST_DREQ) || (state_q == ST_IREQ);
  assign instr_done_o = (state_q == ST_WAIT) && hready_i && (owner_q == SRC_INSTR);
  assign data_done_o  = (state_q == ST_WAIT) && hready_i && (owner_q == SRC_DATA);

endmodule

// File: rtl/bridge_req_regs.sv
module bridge_req_regs
  import ahb_bridge_pkg::*;
#(
  parameter  int unsigned AW   = 32,
  parameter  int unsigned DW   = 32,
  localparam int unsigned BW   = DW / 8,
  localparam int unsigned OFFW = $clog2(BW)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          capture_i,
  input  src_e          cap_src_i,
  input  logic [AW-1:0] instr_addr_i,
  input  logic [AW-1:0] data_addr_i,
  input  logic          data_we_i,
  input  logic [BW-1:0] data_be_i,
  input  logic [DW-1:0] data_wdata_i,
  output logic [AW-1:0] addr_o,
  output logic [2:0]    size_o,
  output logic          we_o,
  output logic [DW-1:0] wdata_o
);

  localparam logic [2:0] FETCH_SIZE = 3'(OFFW);

  logic [2:0]      be_size;
  logic [OFFW-1:0] be_offs;
  logic            unused_addr_lo;

  bridge_be_decode #(.DW(DW)) u_be_decode (
    .be_i   (data_be_i),
    .size_o (be_size),
    .offs_o (be_offs)
  );

  assign unused_addr_lo = ^data_addr_i[OFFW-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o  <= '0;
      size_o  <= '0;
      we_o    <= 1'b0;
      wdata_o <= '0;
    end else if (capture_i) begin
      if (cap_src_i == SRC_DATA) begin
        addr_o  <= {data_addr_i[AW-1:OFFW], be_offs};
        size_o  <= be_size;
        we_o    <= data_we_i;
        wdata_o <= data_wdata_i;
      end else begin
        addr_o  <= instr_addr_i;
        size_o  <= FETCH_SIZE;
        we_o    <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/bridge_resp_route.sv
module bridge_resp_route #(
  parameter int unsigned DW = 32
) (
  input  logic          instr_done_i,
  input  logic          data_done_i,
  input  logic [DW-1:0] hrdata_i,
  output logic          instr_rvalid_o,
  output logic [DW-1:0] instr_rdata_o,
  output logic          data_rvalid_o,
  output logic [DW-1:0] data_rdata_o
);

  assign instr_rvalid_o = instr_done_i;
  assign data_rvalid_o  = data_done_i;
  assign instr_rdata_o  = instr_done_i ? hrdata_i : '0;
  assign data_rdata_o   = data_done_i  ? hrdata_i : '0;

endmodule

// File: rtl/core_ahb_bridge.sv
module core_ahb_bridge
  import ahb_bridge_pkg::*;
#(
  parameter  int unsigned AW = 32,
  parameter  int unsigned DW = 32,
  localparam int unsigned BW = DW / 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          instr_req_i,
  input  logic [AW-1:0] instr_addr_i,
  output logic          instr_gnt_o,
  output logic          instr_rvalid_o,
  output logic [DW-1:0] instr_rdata_o,
  input  logic          data_req_i,
  input  logic          data_we_i,
  input  logic [BW-1:0] data_be_i,
  input  logic [AW-1:0] data_addr_i,
  input  logic [DW-1:0] data_wdata_i,
  output logic          data_gnt_o,
  output logic          data_rvalid_o,
  output logic [DW-1:0] data_rdata_o,
  output logic [AW-1:0] haddr_o,
  output logic [1:0]    htrans_o,
  output logic [2:0]    hsize_o,
  output logic          hwrite_o,
  output logic [DW-1:0] hwdata_o,
  input  logic          hready_i,
  input  logic [DW-1:0] hrdata_i
);

  logic          capture;
  src_e          cap_src;
  logic          addr_phase;
  logic          instr_done;
  logic          data_done;
  logic [AW-1:0] addr_q;
  logic [2:0]    size_q;
  logic          we_q;
  logic [DW-1:0] wdata_q;

  bridge_ctrl u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .instr_req_i  (instr_req_i),
    .data_req_i   (data_req_i),
    .hready_i     (hready_i),
    .capture_o    (capture),
    .cap_src_o    (cap_src),
    .addr_phase_o (addr_phase),
    .instr_gnt_o  (instr_gnt_o),
    .data_gnt_o   (data_gnt_o),
    .instr_done_o (instr_done),
    .data_done_o  (data_done)
  );

  bridge_req_regs #(.AW(AW), .DW(DW)) u_req_regs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .capture_i    (capture),
    .cap_src_i    (cap_src),
    .instr_addr_i (instr_addr_i),
    .data_addr_i  (data_addr_i),
    .data_we_i    (data_we_i),
    .data_be_i    (data_be_i),
    .data_wdata_i (data_wdata_i),
    .addr_o       (addr_q),
    .size_o       (size_q),
    .we_o         (we_q),
    .wdata_o      (wdata_q)
  );

  bridge_resp_route #(.DW(DW)) u_resp_route (
    .instr_done_i   (instr_done),
    .data_done_i    (data_done),
    .hrdata_i       (hrdata_i),
    .instr_rvalid_o (instr_rvalid_o),
    .instr_rdata_o  (instr_rdata_o),
    .data_rvalid_o  (data_rvalid_o),
    .data_rdata_o   (data_rdata_o)
  );

  assign htrans_o = addr_phase ? HTRANS_NONSEQ : HTRANS_IDLE;
  assign haddr_o  = addr_q;
  assign hsize_o  = size_q;
  assign hwrite_o = addr_phase & we_q;
  // registered store data lands in the data phase
  assign hwdata_o = wdata_q;

endmodule

// File: rtl/core_ahb_bridge_checker.sv
module core_ahb_bridge_checker #(
  parameter int unsigned AW = 32,
  parameter int unsigned DW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [AW-1:0] haddr_o,
  input logic [1:0]    htrans_o,
  input logic [2:0]    hsize_o,
  input logic          hwrite_o,
  input logic          hready_i,
  input logic          instr_gnt_o,
  input logic          data_gnt_o,
  input logic          instr_rvalid_o,
  input logic          data_rvalid_o
);

  localparam logic [2:0] MAX_SIZE = 3'($clog2(DW / 8));

  a_r4_htrans_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (htrans_o == 2'b00) || (htrans_o == 2'b10));

  a_r3_gnt_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({instr_gnt_o, data_gnt_o}));

  a_r3_gnt_in_addr_phase: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (instr_gnt_o || data_gnt_o) |-> (htrans_o == 2'b10 && hready_i));

  a_r3_gnt_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (instr_gnt_o || data_gnt_o) |=> !(instr_gnt_o || data_gnt_o));

  a_r7_no_pipelining: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (htrans_o == 2'b10 && hready_i) |=> (htrans_o == 2'b00));

  a_r7_rvalid_needs_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (instr_rvalid_o || data_rvalid_o) |-> (hready_i && htrans_o == 2'b00));

  a_r8_rvalid_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({instr_rvalid_o, data_rvalid_o}));

  a_r9_addr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (htrans_o == 2'b10 && !hready_i) |=>
      (htrans_o == 2'b10 && $stable(haddr_o) && $stable(hsize_o) && $stable(hwrite_o)));

  a_r6_hwrite_addr_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hwrite_o |-> (htrans_o == 2'b10 && !instr_gnt_o));

  a_r5_size_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (htrans_o == 2'b10) |-> (hsize_o <= MAX_SIZE));

endmodule

bind core_ahb_bridge core_ahb_bridge_checker #(.AW(AW), .DW(DW)) u_checker (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .haddr_o        (haddr_o),
  .htrans_o       (htrans_o),
  .hsize_o        (hsize_o),
  .hwrite_o       (hwrite_o),
  .hready_i       (hready_i),
  .instr_gnt_o    (instr_gnt_o),
  .data_gnt_o     (data_gnt_o),
  .instr_rvalid_o (instr_rvalid_o),
  .data_rvalid_o  (data_rvalid_o)
);

// File: tb/core_ahb_bridge_test.sv
module core_ahb_bridge_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        instr_req, instr_gnt, instr_rvalid;
  logic [31:0] instr_addr, instr_rdata;
  logic        data_req, data_we, data_gnt, data_rvalid;
  logic [3:0]  data_be;
  logic [31:0] data_addr, data_wdata, data_rdata;
  logic [31:0] haddr, hwdata, hrdata;
  logic [1:0]  htrans;
  logic [2:0]  hsize;
  logic        hwrite, hready;

  always #5 clk = ~clk;

  core_ahb_bridge uut (
    .clk_i(clk), .rst_ni(rst_n),
    .instr_req_i(instr_req), .instr_addr_i(instr_addr), .instr_gnt_o(instr_gnt),
    .instr_rvalid_o(instr_rvalid), .instr_rdata_o(instr_rdata),
    .data_req_i(data_req), .data_we_i(data_we), .data_be_i(data_be),
    .data_addr_i(data_addr), .data_wdata_i(data_wdata), .data_gnt_o(data_gnt),
    .data_rvalid_o(data_rvalid), .data_rdata_o(data_rdata),
    .haddr_o(haddr), .htrans_o(htrans), .hsize_o(hsize), .hwrite_o(hwrite),
    .hwdata_o(hwdata), .hready_i(hready), .hrdata_i(hrdata)
  );

  typedef struct {
    bit          we;
    logic [3:0]  be;
    logic [31:0] addr;
    logic [31:0] wdata;
  } dreq_t;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int hmode  = 0;
  logic [15:0] lfsr = 16'hace1;

  logic [31:0] iq[$];
  dreq_t       dq[$];

  // reference model: 0 idle, 1 address phase, 2 data phase
  int          ms = 0;
  bit          mown_data, mwe;
  logic [31:0] maddr, mwdata;
  logic [2:0]  msize;
  bit          eig = 0, edg = 0;

  logic [3:0] be_pat [7] = '{4'b0001, 4'b0010, 4'b0100, 4'b1000, 4'b0011, 4'b1100, 4'b1111};

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic model_step();
    int off, cnt;
    case (ms)
      0: begin
        if (data_req) begin
          off = 0;
          for (int k = 3; k >= 0; k--) if (data_be[k]) off = k;
          cnt = $countones(data_be);
          msize     = (cnt == 4) ? 3'd2 : (cnt == 2) ? 3'd1 : 3'd0;
          maddr     = {data_addr[31:2], 2'(off)};
          mwe       = data_we;
          mwdata    = data_wdata;
          mown_data = 1;
          ms        = 1;
        end else if (instr_req) begin
          maddr     = instr_addr;
          msize     = 3'd2;
          mwe       = 0;
          mown_data = 0;
          ms        = 1;
        end
      end
      1: if (hready) ms = 2;
      default: if (hready) ms = 0;
    endcase
  endtask

  task automatic drive_inputs();
    if (edg && dq.size() > 0) void'(dq.pop_front());
    if (eig && iq.size() > 0) void'(iq.pop_front());
    instr_req  = iq.size() > 0;
    instr_addr = (iq.size() > 0) ? iq[0] : 32'h0;
    data_req   = dq.size() > 0;
    if (dq.size() > 0) begin
      data_we = dq[0].we; data_be = dq[0].be; data_addr = dq[0].addr; data_wdata = dq[0].wdata;
    end else begin
      data_we = 0; data_be = 4'h0; data_addr = 32'h0; data_wdata = 32'h0;
    end
    lfsr   = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    hready = (hmode == 0) ? 1'b1 : (hmode == 1) ? lfsr[0] : ((cyc % 4) == 0);
    hrdata = 32'h5a000000 ^ (32'(cyc) * 32'h00010203);
  endtask

  task automatic compare();
    bit eiv, edv;
    chk(htrans == ((ms == 1) ? 2'b10 : 2'b00), "R4 R7 htrans", 32'(htrans), (ms == 1) ? 32'd2 : 32'd0);
    if (ms == 1) begin
      chk(haddr == maddr, "R5 R6 R9 haddr", haddr, maddr);
      chk(hsize == msize, "R5 R9 hsize", 32'(hsize), 32'(msize));
      chk(hwrite == mwe, "R6 hwrite in address phase", 32'(hwrite), 32'(mwe));
    end else begin
      chk(hwrite == 1'b0, "R6 hwrite outside address phase", 32'(hwrite), 32'd0);
    end
    eig = (ms == 1) && hready && !mown_data;
    edg = (ms == 1) && hready && mown_data;
    chk(instr_gnt == eig, "R2 R3 instr grant", 32'(instr_gnt), 32'(eig));
    chk(data_gnt == edg, "R2 R3 data grant", 32'(data_gnt), 32'(edg));
    eiv = (ms == 2) && hready && !mown_data;
    edv = (ms == 2) && hready && mown_data;
    chk(instr_rvalid == eiv, "R7 R8 instr rvalid", 32'(instr_rvalid), 32'(eiv));
    chk(data_rvalid == edv, "R7 R8 data rvalid", 32'(data_rvalid), 32'(edv));
    if (eiv) chk(instr_rdata == hrdata, "R8 instr rdata", instr_rdata, hrdata);
    if (edv) chk(data_rdata == hrdata, "R8 data rdata", data_rdata, hrdata);
    if (ms == 2 && mwe) chk(hwdata == mwdata, "R6 hwdata", hwdata, mwdata);
  endtask

  task automatic cycle();
    @(negedge clk);
    cyc++;
    model_step();
    drive_inputs();
    #1;
    compare();
  endtask

  task automatic drain(input int limit);
    int n = 0;
    while ((iq.size() > 0 || dq.size() > 0 || ms != 0 || eig || edg) && n < limit) begin
      cycle();
      n++;
    end
    if (n >= limit) begin
      fails++;
      $display("FAIL watchdog: traffic did not drain (cycle %0d)", cyc);
    end
    repeat (2) cycle();
  endtask

  function automatic dreq_t mk(input bit we, input logic [3:0] be, input logic [31:0] a, input logic [31:0] d);
    dreq_t r;
    r.we = we; r.be = be; r.addr = a; r.wdata = d;
    return r;
  endfunction

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog: global timeout");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 0; instr_req = 0; instr_addr = 0; data_req = 0; data_we = 0;
    data_be = 0; data_addr = 0; data_wdata = 0; hready = 1; hrdata = 0;
    // R1: outputs while reset is held, even with requests pending
    repeat (2) @(negedge clk);
    instr_req = 1; data_req = 1; data_be = 4'hf;
    @(negedge clk); #1;
    chk(htrans == 2'b00, "R1 reset htrans", 32'(htrans), 32'd0);
    chk(hwrite == 1'b0, "R1 reset hwrite", 32'(hwrite), 32'd0);
    chk({instr_gnt, data_gnt} == 2'b00, "R1 reset grants", 32'({instr_gnt, data_gnt}), 32'd0);
    chk({instr_rvalid, data_rvalid} == 2'b00, "R1 reset rvalid", 32'({instr_rvalid, data_rvalid}), 32'd0);
    instr_req = 0; data_req = 0; data_be = 0;
    @(negedge clk);
    rst_n = 1;

    // fetches only, slave always ready (R6 word fetch)
    hmode = 0;
    for (int i = 0; i < 4; i++) iq.push_back(32'h0000_1000 + 32'(i * 4));
    drain(100);

    // loads and stores with every enable pattern, dirty low address bits (R5)
    for (int i = 0; i < 7; i++) dq.push_back(mk(0, be_pat[i], 32'h2000_0040 + 32'(i * 4) + 32'(i % 4), 32'h0));
    drain(200);
    for (int i = 0; i < 7; i++) dq.push_back(mk(1, be_pat[i], 32'h2000_0100 + 32'(i * 8) + 32'(3 - (i % 4)), 32'hc0de_0000 + 32'(i)));
    drain(200);

    // simultaneous requests: data port first (R2)
    for (int i = 0; i < 3; i++) begin
      iq.push_back(32'h0000_2000 + 32'(i * 4));
      dq.push_back(mk(i[0], be_pat[i + 3], 32'h2000_0200 + 32'(i * 4), 32'hbeef_0000 + 32'(i)));
    end
    drain(200);

    // pseudo-random ready with mixed traffic (R7 R9)
    hmode = 1;
    for (int i = 0; i < 12; i++) begin
      iq.push_back(32'h0000_3000 + 32'(i * 4));
      dq.push_back(mk(lfsr[i % 16], be_pat[i % 7], 32'h2000_0300 + 32'(i * 4), 32'h1234_0000 ^ 32'(i * 77)));
    end
    drain(2000);

    // long stalls: ready high one cycle in four (R7 R9)
    hmode = 2;
    for (int i = 0; i < 5; i++) begin
      iq.push_back(32'h0000_4000 + 32'(i * 4));
      dq.push_back(mk(1, be_pat[(i * 3) % 7], 32'h2000_0400 + 32'(i * 4), 32'ha5a5_0000 + 32'(i)));
    end
    drain(2000);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule